// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Controller

This block watches the stream of instructions that a processor commits and raises a debug break request when an executed instruction's fetch address equals an address that software has programmed. It has two comparator channels. Each channel has its own match address, an enable for the fetch-address condition, a break enable and a select that places the break either before or after the matched instruction. Each channel also keeps a sticky match flag that software clears by writing a one to it.

The processor presents one instruction per cycle. With each instruction it gives the fetch address, a qualifier showing that the instruction really executes, markers for delayed branches and their delay slots, and a global block bit. While the block bit is set, matches are still recorded in the flags but no request is raised. A pre-execution match on a delay slot is reported against the owning branch. A post-execution match on a delayed branch or on its slot is held until the first instruction at the branch target.

A sequential mode chains the channels. Channel 1 raises a break only after channel 0 has already matched. Software re-arms the chain by clearing channel 0's flag. Each instruction produces at most one request.

Top module: `ifetch_brk_ctrl`

## Requirements
- R1: A write with `reg_we` high takes effect at the next clock edge. The `reg_sel` codes are: 0 = channel 0 address, 1 = channel 0 control, 2 = channel 1 address, 3 = channel 1 control, 4 = flag clear (bit 0 clears channel 0, bit 1 clears channel 1), 5 = mode (bit 0 selects sequential). The control bits are: bit 0 = fetch-address condition enable, bit 1 = break enable, bit 2 = post-execution timing. A channel is compared only on a cycle with `in_valid` high, and a match sets its flag at the next edge.
- R2: A channel whose programmed address has bit 0 set never matches. Its flag stays clear and it raises no break.
- R3: A match on a channel with break enable clear sets the flag but raises no request.
- R4: While `blk` is 1 on the matched instruction, no request results from that match, but the flag is still set.
- R5: A pre-execution break shows `brk_req`=1, `brk_post`=0 and `brk_addr` equal to the matched address one cycle after the instruction.
- R6: A post-execution break is raised one cycle after the next executed instruction that is not a delay slot, with `brk_post`=1 and `brk_addr` equal to that instruction's address.
- R7: A pre-execution match on a delay slot reports `brk_addr` equal to the address of the preceding delayed branch.
- R8: A post-execution match on a delayed branch or on its delay slot is raised at the first instruction after the slot. It is never raised on the slot itself.
- R9: In sequential mode, channel 0 never requests a break. Channel 1 requests one only if channel 0's flag was already set before channel 1's matching instruction. Both flags still set on every match.
- R10: In sequential mode, clearing channel 0's flag before channel 1 matches returns the chain to its initial state.
- R11: Flags are sticky and cleared by writing a one to them. A match in the same cycle as a clear of that flag leaves the flag set.
- R12: At most one request is raised per instruction. When a pre-execution break and a post-execution break fall on the same instruction, the pre-execution break wins and the post-execution one is dropped.
- R13: Bit 3 of channel 1's control word, the data-compare enable, has no effect on fetch matching.
- R14: After reset, `brk_req`, `match_flag` and all configuration are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | AW | Register write data |
| in_valid | input | 1 | Instruction presented and executes |
| in_addr | input | AW | Fetch address of the instruction |
| in_slot | input | 1 | Instruction is a delay slot |
| in_dbr | input | 1 | Instruction is a delayed branch |
| blk | input | 1 | Global break block bit |
| brk_req | output | 1 | Break request pulse |
| brk_post | output | 1 | Request is post-execution (1) or pre-execution (0) |
| brk_addr | output | AW | Address of the instruction before which the break is taken |
| match_flag | output | 2 | Sticky per-channel match flags |

## Verification
Match flags and pre-execution requests are due at the first rising edge after the instruction is presented. A post-execution request is due one edge after the next executed instruction that is not a delay slot, and a register write is visible from the edge that captures it. The bench drives every input on the falling edge and compares the outputs on the following falling edge, so each comparison sees exactly one registered update. A reference model in the bench steps once per presented instruction and carries the pending post-execution state over idle cycles and register writes.

// File: rtl/ibc_pkg.sv
// Package: shared types and register select codes for the instruction
// breakpoint controller. Assumes exactly two channels in the register map.
package ibc_pkg;

    typedef struct packed {
        logic post;      // 1: break after the instruction executes
        logic brk_en;    // 1: a match may raise a request
        logic fetch_en;  // 1: fetch-address condition is enabled
    } chan_ctrl_t;

    localparam int NCH = 2;

    localparam logic [2:0] SEL_CLR  = 3'd4;
    localparam logic [2:0] SEL_MODE = 3'd5;

endpackage

// File: rtl/ibc_regs.sv
// Module: configuration registers. Each channel holds an address and a control
// word. Also holds the sequential mode bit and decodes flag-clear writes into a
// one-cycle mask. Assumes AW >= 3. Bits of a control word above bit 2 are not
// stored, so the data-compare enable of channel 1 has no effect.
module ibc_regs
    import ibc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    ch_addr [NCH],
    output chan_ctrl_t       ch_ctrl [NCH],
    output logic [NCH-1:0]   clr_mask,
    output logic             seq_mode
);

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            localparam logic [2:0] SEL_A = 3'(2 * gi);
            localparam logic [2:0] SEL_C = 3'(2 * gi + 1);

            // Capture the address and control writes for this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ch_addr[gi] <= '0;
                    ch_ctrl[gi] <= '0;
                end else if (reg_we) begin
                    if (reg_sel == SEL_A)
                        ch_addr[gi] <= reg_wdata;
                    if (reg_sel == SEL_C)
                        ch_ctrl[gi] <= '{post: reg_wdata[2], brk_en: reg_wdata[1],
                                         fetch_en: reg_wdata[0]};
                end
            end
        end
    endgenerate

    // Capture the mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_mode <= 1'b0;
        else if (reg_we && reg_sel == SEL_MODE)
            seq_mode <= reg_wdata[0];
    end

    // Decode a write-one-to-clear strobe for the flags.
    always_comb begin
        clr_mask = '0;
        if (reg_we && reg_sel == SEL_CLR)
            clr_mask = reg_wdata[NCH-1:0];
    end

endmodule

// File: rtl/ibc_chan.sv
// Module: one comparator channel. Compares the address of an executed
// instruction with the programmed address and keeps a sticky match flag. An odd
// programmed address never matches. A new match beats a clear in the same cycle.
module ibc_chan #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [AW-1:0] cfg_addr,
    input  logic          fetch_en,
    input  logic          clr,
    output logic          hit,
    output logic          flag_q
);

    // Match only executed instructions against a legal (even) address.
    always_comb begin
        hit = in_valid && fetch_en && !cfg_addr[0] && (in_addr == cfg_addr);
    end

    // Sticky flag: set on a match, clear on a write of one, match wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= (flag_q && !clr) || hit;
    end

endmodule

// File: rtl/ibc_sched.sv
// Module: break scheduler. Turns channel matches into at most one request per
// executed instruction. It applies the block bit, the sequential chain and the
// pre/post timing. It holds pending post breaks across delay slots and
// remembers the last delayed-branch address for pre breaks on slots. Assumes a
// delay slot is the next executed instruction after its delayed branch.
module ibc_sched #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          in_slot,
    input  logic          in_dbr,
    input  logic          blk,
    input  logic          seq_mode,
    input  logic          flag0_q,
    input  logic [1:0]    hit,
    input  logic [1:0]    brk_en,
    input  logic [1:0]    post_sel,
    output logic          brk_req,
    output logic          brk_post,
    output logic [AW-1:0] brk_addr
);

    logic [1:0]    fire;
    logic          pre_fire;
    logic          post_fire;
    logic [AW-1:0] pre_addr;
    logic [AW-1:0] dbr_addr_q;
    logic          pend_q;

    // Decide which channels request a break on this instruction.
    always_comb begin
        fire[0] = hit[0] && brk_en[0] && !seq_mode;
        fire[1] = hit[1] && brk_en[1] && (!seq_mode || flag0_q);
        if (blk)
            fire = 2'b00;
        pre_fire  = |(fire & ~post_sel);
        post_fire = |(fire & post_sel);
        pre_addr  = in_slot ? dbr_addr_q : in_addr;
    end

    // Issue requests, track pending post breaks and the last branch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req    <= 1'b0;
            brk_post   <= 1'b0;
            brk_addr   <= '0;
            dbr_addr_q <= '0;
            pend_q     <= 1'b0;
        end else begin
            brk_req <= 1'b0;
            if (in_valid) begin
                if (in_dbr)
                    dbr_addr_q <= in_addr;
                if (pre_fire) begin
                    brk_req  <= 1'b1;
                    brk_post <= 1'b0;
                    brk_addr <= pre_addr;
                    pend_q   <= 1'b0;
                end else if (pend_q && !in_slot) begin
                    brk_req  <= 1'b1;
                    brk_post <= 1'b1;
                    brk_addr <= in_addr;
                    pend_q   <= post_fire;
                end else begin
                    pend_q <= pend_q || post_fire;
                end
            end
        end
    end

endmodule

// File: rtl/ifetch_brk_ctrl.sv
// Module: top of the two-channel instruction breakpoint controller. Connects
// the register block, one comparator per channel and the break scheduler.
// Assumes one executed instruction per cycle at most, given by in_valid.
module ifetch_brk_ctrl
    import ibc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic          in_slot,
    input  logic          in_dbr,
    input  logic          blk,
    output logic          brk_req,
    output logic          brk_post,
    output logic [AW-1:0] brk_addr,
    output logic [1:0]    match_flag
);

    logic [AW-1:0]  ch_addr [NCH];
    chan_ctrl_t     ch_ctrl [NCH];
    logic [NCH-1:0] clr_mask;
    logic           seq_mode;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] brk_en_v;
    logic [NCH-1:0] post_v;

    ibc_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ch_addr   (ch_addr),
        .ch_ctrl   (ch_ctrl),
        .clr_mask  (clr_mask),
        .seq_mode  (seq_mode)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            ibc_chan #(.AW(AW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (in_valid),
                .in_addr  (in_addr),
                .cfg_addr (ch_addr[gi]),
                .fetch_en (ch_ctrl[gi].fetch_en),
                .clr      (clr_mask[gi]),
                .hit      (hit[gi]),
                .flag_q   (match_flag[gi])
            );
            assign brk_en_v[gi] = ch_ctrl[gi].brk_en;
            assign post_v[gi]   = ch_ctrl[gi].post;
        end
    endgenerate

    ibc_sched #(.AW(AW)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_slot  (in_slot),
        .in_dbr   (in_dbr),
        .blk      (blk),
        .seq_mode (seq_mode),
        .flag0_q  (match_flag[0]),
        .hit      (hit),
        .brk_en   (brk_en_v),
        .post_sel (post_v),
        .brk_req  (brk_req),
        .brk_post (brk_post),
        .brk_addr (brk_addr)
    );

endmodule

// File: rtl/ibc_checker.sv
// Module: assertion checker for the breakpoint controller, bound to the top.
module ibc_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_sel,
    input logic [AW-1:0] reg_wdata,
    input logic          in_valid,
    input logic [AW-1:0] in_addr,
    input logic          in_slot,
    input logic          blk,
    input logic          seq_mode,
    input logic          brk_req,
    input logic          brk_post,
    input logic [1:0]    match_flag
);

    // R1: no request without an executed instruction on the previous cycle
    a_r1_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !brk_req);

    // R2: an odd fetch address can never set a clear flag
    a_r2_odd_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[0] && match_flag == 2'b00) |=> match_flag == 2'b00);

    // R4: a blocked instruction yields no pre-execution request
    a_r4_block_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blk) |=> !(brk_req && !brk_post));

    // R8: post-execution requests never land on a delay slot
    a_r8_no_post_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_slot) |=> !(brk_req && brk_post));

    // R9: sequential chain cannot fire a pre break before channel 0 flagged
    a_r9_seq_needs_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && in_valid && !match_flag[0]) |=> !(brk_req && !brk_post));

    // R11: flag 0 holds unless cleared by a write of one
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag[0] && !(reg_we && reg_sel == 3'd4 && reg_wdata[0])) |=> match_flag[0]);

endmodule

bind ifetch_brk_ctrl ibc_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_slot    (in_slot),
    .blk        (blk),
    .seq_mode   (seq_mode),
    .brk_req    (brk_req),
    .brk_post   (brk_post),
    .match_flag (match_flag)
);

// File: tb/sim_ifetch_brk_ctrl.sv
`timescale 1ns/1ps
module sim_ifetch_brk_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        in_slot = 1'b0;
    logic        in_dbr = 1'b0;
    logic        blk = 1'b0;
    logic        brk_req;
    logic        brk_post;
    logic [31:0] brk_addr;
    logic [1:0]  match_flag;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] b_addr [2];
    logic [3:0]  b_ctrl [2];
    bit          b_seq;
    bit [1:0]    m_flag;
    bit          m_pend;
    logic [31:0] m_dbr;

    always #2.5 clk = ~clk;

    ifetch_brk_ctrl #(.AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .in_slot(in_slot), .in_dbr(in_dbr), .blk(blk), .brk_req(brk_req),
        .brk_post(brk_post), .brk_addr(brk_addr), .match_flag(match_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel == 3'd0 || sel == 3'd2) b_addr[sel[1]] = data;
        if (sel == 3'd1 || sel == 3'd3) b_ctrl[sel[1]] = data[3:0];
        if (sel == 3'd4) m_flag = m_flag & ~data[1:0];
        if (sel == 3'd5) b_seq = data[0];
    endtask

    task automatic ins(input logic [31:0] a, input bit s, input bit d, input bit b);
        in_valid = 1'b1; in_addr = a; in_slot = s; in_dbr = d; blk = b;
        @(negedge clk);
        in_valid = 1'b0; in_slot = 1'b0; in_dbr = 1'b0; blk = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic expect_brk(input string tag, input bit req, input bit post, input logic [31:0] a);
        chk({tag, " req"}, 32'(brk_req), 32'(req));
        if (req) begin
            chk({tag, " post"}, 32'(brk_post), 32'(post));
            chk({tag, " addr"}, brk_addr, a);
        end
    endtask

    function automatic bit m_hit(input int i, input logic [31:0] a);
        return b_ctrl[i][0] && !b_addr[i][0] && (a == b_addr[i]);
    endfunction

    // model one executed instruction, drive it, compare
    task automatic step(input logic [31:0] a, input bit s, input bit d, input bit b);
        bit h0, h1, f0, f1, pre, pst, e_req, e_post;
        logic [31:0] e_addr;
        h0 = m_hit(0, a); h1 = m_hit(1, a);
        f0 = h0 && b_ctrl[0][1] && !b_seq && !b;
        f1 = h1 && b_ctrl[1][1] && (!b_seq || m_flag[0]) && !b;
        pre = (f0 && !b_ctrl[0][2]) || (f1 && !b_ctrl[1][2]);
        pst = (f0 && b_ctrl[0][2]) || (f1 && b_ctrl[1][2]);
        e_req = 0; e_post = 0; e_addr = '0;
        if (pre) begin
            e_req = 1; e_addr = s ? m_dbr : a; m_pend = 0;
        end else if (m_pend && !s) begin
            e_req = 1; e_post = 1; e_addr = a; m_pend = pst;
        end else begin
            m_pend = m_pend || pst;
        end
        if (d) m_dbr = a;
        m_flag = m_flag | {h1, h0};
        ins(a, s, d, b);
        expect_brk("R12 random", e_req, e_post, e_addr);
        chk("R11 random flags", 32'(match_flag), 32'(m_flag));
    endtask

    function automatic logic [31:0] pool_addr();
        case ($urandom % 5)
            0: return 32'h10;
            1: return 32'h12;
            2: return 32'h14;
            3: return 32'h16;
            default: return 32'h11;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        b_addr[0] = '0; b_addr[1] = '0; b_ctrl[0] = '0; b_ctrl[1] = '0;
        b_seq = 0; m_flag = '0; m_pend = 0; m_dbr = '0;
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R14 reset state
        chk("R14 req", 32'(brk_req), 0);
        chk("R14 flags", 32'(match_flag), 0);
        ins(32'h100, 0, 0, 0);
        expect_brk("R14 unconfigured", 0, 0, 0);

        // R1 / R5 basic pre break
        wr(3'd0, 32'h100); wr(3'd1, 32'h3);
        ins(32'h100, 0, 0, 0);
        expect_brk("R5 pre", 1, 0, 32'h100);
        chk("R1 flag set", 32'(match_flag), 1);
        wr(3'd4, 32'h1);
        chk("R11 w1c", 32'(match_flag), 0);
        in_addr = 32'h100; in_valid = 1'b0; idle();
        chk("R1 invalid req", 32'(brk_req), 0);
        chk("R1 invalid flag", 32'(match_flag), 0);

        // R3 no break enable
        wr(3'd1, 32'h1);
        ins(32'h100, 0, 0, 0);
        expect_brk("R3 no bie", 0, 0, 0);
        chk("R3 flag", 32'(match_flag), 1);
        wr(3'd4, 32'h1);

        // R4 block bit
        wr(3'd1, 32'h3);
        ins(32'h100, 0, 0, 1);
        expect_brk("R4 blocked", 0, 0, 0);
        chk("R4 flag", 32'(match_flag), 1);
        wr(3'd4, 32'h1);

        // R2 odd programmed address
        wr(3'd0, 32'h101);
        ins(32'h101, 0, 0, 0);
        expect_brk("R2 odd", 0, 0, 0);
        chk("R2 flag", 32'(match_flag), 0);
        wr(3'd0, 32'h100);

        // R6 post break at next instruction
        wr(3'd1, 32'h7);
        ins(32'h100, 0, 0, 0);
        expect_brk("R6 none yet", 0, 0, 0);
        ins(32'h102, 0, 0, 0);
        expect_brk("R6 post", 1, 1, 32'h102);
        wr(3'd4, 32'h1);

        // R8 post on delayed branch, then on slot
        wr(3'd0, 32'h200);
        ins(32'h200, 0, 1, 0); expect_brk("R8 branch", 0, 0, 0);
        ins(32'h202, 1, 0, 0); expect_brk("R8 slot", 0, 0, 0);
        ins(32'h300, 0, 0, 0); expect_brk("R8 target", 1, 1, 32'h300);
        wr(3'd0, 32'h202);
        ins(32'h200, 0, 1, 0); expect_brk("R8 branch2", 0, 0, 0);
        ins(32'h202, 1, 0, 0); expect_brk("R8 slot2", 0, 0, 0);
        ins(32'h340, 0, 0, 0); expect_brk("R8 target2", 1, 1, 32'h340);

        // R7 pre on slot reports branch address
        wr(3'd1, 32'h3);
        ins(32'h200, 0, 1, 0); expect_brk("R7 branch", 0, 0, 0);
        ins(32'h202, 1, 0, 0); expect_brk("R7 slot", 1, 0, 32'h200);
        wr(3'd4, 32'h3);

        // R12 pre beats post on the same instruction
        wr(3'd0, 32'h400); wr(3'd1, 32'h7);
        wr(3'd2, 32'h400); wr(3'd3, 32'h3);
        ins(32'h400, 0, 0, 0); expect_brk("R12 pre wins", 1, 0, 32'h400);
        ins(32'h402, 0, 0, 0); expect_brk("R12 post dropped", 0, 0, 0);
        chk("R12 flags", 32'(match_flag), 3);
        wr(3'd4, 32'h3);

        // R13 data-compare enable ignored
        wr(3'd1, 32'h0); wr(3'd3, 32'hB);
        ins(32'h400, 0, 0, 0); expect_brk("R13 dce set", 1, 0, 32'h400);
        wr(3'd4, 32'h3);
        wr(3'd3, 32'h8);
        ins(32'h400, 0, 0, 0); expect_brk("R13 dce only", 0, 0, 0);
        chk("R13 flag", 32'(match_flag), 0);

        // R9 sequential chain
        wr(3'd5, 32'h1);
        wr(3'd0, 32'h500); wr(3'd1, 32'h3);
        wr(3'd2, 32'h600); wr(3'd3, 32'h3);
        ins(32'h600, 0, 0, 0); expect_brk("R9 ch1 first", 0, 0, 0);
        chk("R9 ch1 flag", 32'(match_flag), 2);
        ins(32'h500, 0, 0, 0); expect_brk("R9 ch0 silent", 0, 0, 0);
        chk("R9 both flags", 32'(match_flag), 3);
        ins(32'h600, 0, 0, 0); expect_brk("R9 chain fires", 1, 0, 32'h600);

        // R10 release by clearing channel 0
        wr(3'd4, 32'h3);
        ins(32'h500, 0, 0, 0);
        wr(3'd4, 32'h1);
        ins(32'h600, 0, 0, 0); expect_brk("R10 released", 0, 0, 0);

        // R11 match beats clear in the same cycle
        wr(3'd5, 32'h0); wr(3'd4, 32'h3);
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h1;
        in_valid = 1'b1; in_addr = 32'h500;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        chk("R11 match wins", 32'(match_flag[0]), 1);

        // constrained random against the model
        do_reset();
        for (int r = 0; r < 10; r++) begin
            bit last_dbr;
            wr(3'd0, pool_addr()); wr(3'd1, 32'($urandom % 16));
            wr(3'd2, pool_addr()); wr(3'd3, 32'($urandom % 16));
            wr(3'd5, 32'($urandom % 2));
            last_dbr = 0;
            for (int k = 0; k < 300; k++) begin
                if (!last_dbr && ($urandom % 10) == 0) begin
                    if (($urandom % 2) == 0) idle();
                    else wr(3'd4, 32'($urandom % 4));
                end else begin
                    bit d;
                    d = !last_dbr && (($urandom % 6) == 0);
                    step(pool_addr(), last_dbr, d, ($urandom % 8) == 0);
                    last_dbr = d;
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule